// File: doc/BRIEF.md
# Memory-Mapped 32-Pin I/O Port

This block is a general-purpose I/O port of 32 pins behind a plain register interface: an address, a write data word, a write strobe and a read data word. It keeps an output latch and a per-pin direction mask, and it samples the pad input levels through a two-stage synchronizer. Every pin is one bit position in each register.

The output latch can be written whole. It can also be changed without a read-modify-write, through three alias addresses: one sets bits, one clears bits and one inverts bits, and each acts only where the written word holds a 1. The pads appear as separate vectors: output value, output enable and input level. Each output enable follows its direction bit, and each output value follows its latch bit.

Top module: `gpio_port_top`

## Requirements
- R1: After reset the latch and the direction register are zero, so every pad output enable is 0 and every pad output value is 0.
- R2: A write to offset 0x00 loads the whole latch. A read of 0x00 returns the latch, and the new value is visible on the cycle after the write.
- R3: A write to offset 0x04 sets each latch bit where the written word holds 1 and leaves the other latch bits as they were.
- R4: A write to offset 0x08 clears each latch bit where the written word holds 1 and leaves the other latch bits as they were.
- R5: A write to offset 0x0C inverts each latch bit where the written word holds 1 and leaves the other latch bits as they were.
- R6: Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R7: Offset 0x10 returns the pad input levels after a two-flop synchronizer. A change at the pads shows in the read data after two rising clock edges. Writes to 0x10 change neither the latch nor the direction register.
- R8: Offset 0x14 is the direction register, readable and writable. A 1 bit makes the pin an output and a 0 bit makes it an input.
- R9: Pad output enable bit n equals direction bit n, and pad output value bit n equals latch bit n, one cycle after the write that changes them.
- R10: Reads and writes of any other offset return zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data word |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values (latch) |
| pad_oe | output | 32 | Pad output enables (direction) |

## Verification
A register write takes effect at the next rising edge. The bench therefore drives each write before an edge and samples the pads and the read data half a period after that edge. Read data is combinational from the registers, so a read is sampled in the same cycle as its address. A change at pad_in needs two edges before offset 0x10 shows it. The bench reads the old value after one edge and the new value after the second edge, which also checks that the delay is exactly two stages.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PinCount  = 32;
  localparam int unsigned AddrWidth = 8;

  localparam logic [AddrWidth-1:0] OffLatch  = 8'h00;
  localparam logic [AddrWidth-1:0] OffSet    = 8'h04;
  localparam logic [AddrWidth-1:0] OffClr    = 8'h08;
  localparam logic [AddrWidth-1:0] OffToggle = 8'h0C;
  localparam logic [AddrWidth-1:0] OffInput  = 8'h10;
  localparam logic [AddrWidth-1:0] OffDir    = 8'h14;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_SET,
    OP_CLR,
    OP_TOGGLE
  } latch_op_e;

  typedef struct packed {
    latch_op_e op;
    logic      dir_we;
  } wr_ctl_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned Width  = 32,
  parameter int unsigned Stages = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [Width-1:0] async_in,
  output logic [Width-1:0] sync_out
);
  logic [Width-1:0] stage_q [Stages];
  logic [Width-1:0] stage_d [Stages];

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < Stages; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar g = 0; g < Stages; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_out = stage_q[Stages-1];

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> sync_out == $past(async_in, 2)); // R7
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
(
  input  logic [AddrWidth-1:0] addr,
  input  logic                 we,
  output wr_ctl_t              ctl
);
  always_comb begin
    ctl.op     = OP_NONE;
    ctl.dir_we = 1'b0;
    if (we) begin
      unique case (addr)
        OffLatch:  ctl.op     = OP_LOAD;
        OffSet:    ctl.op     = OP_SET;
        OffClr:    ctl.op     = OP_CLR;
        OffToggle: ctl.op     = OP_TOGGLE;
        OffDir:    ctl.dir_we = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned Width = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_ctl_t          ctl,
  input  logic [Width-1:0] wdata,
  output logic [Width-1:0] latch_q,
  output logic [Width-1:0] dir_q
);
  logic [Width-1:0] latch_d, dir_d;
  logic             latch_en;

  always_comb begin
    latch_en = (ctl.op != OP_NONE);
    unique case (ctl.op)
      OP_LOAD:   latch_d = wdata;
      OP_SET:    latch_d = latch_q | wdata;
      OP_CLR:    latch_d = latch_q & ~wdata;
      OP_TOGGLE: latch_d = latch_q ^ wdata;
      default:   latch_d = latch_q;
    endcase
    dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dir_q <= '0;
    else if (ctl.dir_we) dir_q <= dir_d;
  end

  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.op == OP_SET |=> (latch_q & $past(wdata)) == $past(wdata)
      && (latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata))); // R3
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.op == OP_CLR |=> (latch_q & $past(wdata)) == '0
      && (latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata))); // R4
  AST_TOG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.op == OP_TOGGLE |=> (latch_q ^ $past(latch_q)) == $past(wdata)); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.op == OP_NONE |=> $stable(latch_q)); // R10
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.dir_we |=> $stable(dir_q)); // R8
endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
  import gpio_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AddrWidth-1:0] bus_addr,
  input  logic [PinCount-1:0]  bus_wdata,
  input  logic                 bus_we,
  output logic [PinCount-1:0]  bus_rdata,
  input  logic [PinCount-1:0]  pad_in,
  output logic [PinCount-1:0]  pad_out,
  output logic [PinCount-1:0]  pad_oe
);
  wr_ctl_t              ctl;
  logic [PinCount-1:0]  latch_q, dir_q, in_sync;

  gpio_addr_dec i_dec (.addr(bus_addr), .we(bus_we), .ctl(ctl));

  gpio_out_regs #(.Width(PinCount)) i_regs (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_in_sync #(.Width(PinCount), .Stages(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(in_sync)
  );

  always_comb begin
    unique case (bus_addr)
      OffLatch: bus_rdata = latch_q;
      OffInput: bus_rdata = in_sync;
      OffDir:   bus_rdata = dir_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;

  AST_ALIAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OffSet || bus_addr == OffClr || bus_addr == OffToggle)
      |-> bus_rdata == '0); // R6
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == OffLatch |=> pad_out == $past(bus_wdata)); // R2
  AST_DIR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == OffDir |=> pad_oe == $past(bus_wdata)); // R8
  AST_INPUT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == OffInput |=> $stable(pad_out) && $stable(pad_oe)); // R7
endmodule

// File: tb/test_gpio_port_top.sv
`timescale 1ns/1ps
module test_gpio_port_top;
  logic        clk = 0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model_latch, model_dir;

  always #2.5 clk = ~clk;

  gpio_port_top i_gpio_port_top (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, the write lands at the next posedge, sample at the following negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #0.5;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    rd_chk("R1 latch", 8'h00, 32'h0);
    rd_chk("R1 dir", 8'h14, 32'h0);
  endtask

  task automatic t_load;
    model_latch = 32'hA5C3_0F81;
    wr(8'h00, model_latch);
    rd_chk("R2 latch read", 8'h00, model_latch);
    chk("R9 pad_out", pad_out, model_latch);
  endtask

  task automatic t_aliases;
    wr(8'h04, 32'h0000_FFFF); model_latch |= 32'h0000_FFFF;
    chk("R3 set", pad_out, model_latch);
    wr(8'h08, 32'hF000_00F0); model_latch &= ~32'hF000_00F0;
    chk("R4 clr", pad_out, model_latch);
    wr(8'h0C, 32'h8000_0001); model_latch ^= 32'h8000_0001;
    chk("R5 toggle", pad_out, model_latch);
    wr(8'h0C, 32'hFFFF_FFFF); model_latch ^= 32'hFFFF_FFFF;
    chk("R5 toggle all", pad_out, model_latch);
    wr(8'h04, 32'h0); chk("R3 zero set", pad_out, model_latch);
    rd_chk("R6 set rd", 8'h04, 32'h0);
    rd_chk("R6 clr rd", 8'h08, 32'h0);
    rd_chk("R6 tog rd", 8'h0C, 32'h0);
  endtask

  task automatic t_dir;
    model_dir = 32'h1234_8765;
    wr(8'h14, model_dir);
    rd_chk("R8 dir read", 8'h14, model_dir);
    chk("R9 pad_oe", pad_oe, model_dir);
    chk("R8 latch kept", pad_out, model_latch);
  endtask

  task automatic t_input;
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk); @(negedge clk);
    rd_chk("R7 settle", 8'h10, 32'hDEAD_BEEF);
    pad_in = 32'h0BAD_F00D;
    @(negedge clk);
    rd_chk("R7 one edge", 8'h10, 32'hDEAD_BEEF);
    @(negedge clk);
    rd_chk("R7 two edges", 8'h10, 32'h0BAD_F00D);
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R7 ro latch", pad_out, model_latch);
    chk("R7 ro dir", pad_oe, model_dir);
  endtask

  task automatic t_unmapped;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h20, 32'h5555_5555);
    chk("R10 latch", pad_out, model_latch);
    chk("R10 dir", pad_oe, model_dir);
    rd_chk("R10 read", 8'h18, 32'h0);
    rd_chk("R10 read2", 8'h01, 32'h0);
  endtask

  initial begin
    fork
      begin
        rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_we = 0; pad_in = 0;
        model_latch = 0; model_dir = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load();
        t_aliases();
        t_dir();
        t_input();
        t_unmapped();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule